// File: doc/BRIEF.md
# SD Command Response Checker

This block watches the card's CMD line after the host has finished sending a command and decides how that command ended. It waits a fixed window of card clock cycles for the response start bit. If the start bit never comes, it raises a timeout. Otherwise it shifts the response in one bit per clock. It runs a serial CRC7 over the leading part of the response and compares the result with the CRC the card sent. It compares the echoed command index with the index the host sent, and it checks that the final bit of the response is 1. When every check passes, a completion pulse is raised. For commands that expect no response, the completion pulse follows the command end bit directly.

The host side drives a one-cycle `cmd_sent` strobe in the cycle of the command end bit. In that same cycle it presents the expected index, the response kind and the two check enables, and the block captures all of them. The CMD line is a plain serial pin that is sampled on every rising edge of `clk`, which is the card clock. A wire cannot be stalled, so this block has no valid/ready interface and no back-pressure. The downstream logic must accept each result pulse in the cycle it appears. All outputs are single-cycle pulses.

Top module: `sd_rsp_checker`

## Requirements
- R1: While reset is held, and after it is released with no command, all five outputs are 0.
- R2: With `rsp_type` = 2'b00 (no response) at the `cmd_sent` cycle T, `cmd_done` is 1 in cycle T+1 only, and no error output rises.
- R3: With a response expected, if `cmd_in` stays 1 during each of the 64 cycles T+1..T+64, `err_timeout` pulses in cycle T+65 and `cmd_done` does not rise for that command.
- R4: A start bit (0) sampled in any of the cycles T+1..T+64 is accepted, including in cycle T+64 for a reply that would normally come within 5 cycles; no timeout is raised, and none is raised before cycle T+65.
- R5: A short response (`rsp_type` 2'b01 or 2'b11) is 48 bits, most significant first: start bit, transmission bit, 6-bit index, 32-bit argument, 7-bit CRC, end bit. If all checks pass, `cmd_done` pulses in the cycle after the end bit is sampled.
- R6: An end bit sampled as 0 raises `err_endbit` in the cycle after it is sampled, for both short and long responses.
- R7: The CRC7 (polynomial x^7+x^3+1, initial value 0) covers the first 40 bits of a short response. A mismatch with the received CRC field raises `err_crc` only when `crc_chk_en` was 1 at the `cmd_sent` cycle.
- R8: A received index that differs from `exp_idx` raises `err_index` only when `idx_chk_en` was 1 at the `cmd_sent` cycle.
- R9: A long response (`rsp_type` 2'b10) is 136 bits; it never raises `err_crc` or `err_index` and only its end bit is checked.
- R10: A `cmd_sent` strobe arriving while a response is still awaited or being received is ignored and does not produce `cmd_done`.
- R11: `cmd_done` is never 1 in a cycle in which any error output is 1; any error for a command suppresses its `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock; CMD sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 1 | Serial CMD line from the card |
| cmd_sent | input | 1 | Pulse in the command end bit cycle |
| rsp_type | input | 2 | 00 none, 01/11 short 48-bit, 10 long 136-bit |
| exp_idx | input | 6 | Index of the command just sent |
| crc_chk_en | input | 1 | Enables CRC7 error reporting |
| idx_chk_en | input | 1 | Enables index mismatch reporting |
| err_timeout | output | 1 | Pulse: no start bit within the window |
| err_crc | output | 1 | Pulse: CRC7 mismatch |
| err_endbit | output | 1 | Pulse: end bit was 0 |
| err_index | output | 1 | Pulse: echoed index mismatch |
| cmd_done | output | 1 | Pulse: command completed without error |

## Verification
A wrong bit counter or field capture would show up as a wrong result pulse one cycle after the end bit. The pulse would be a spurious CRC or index error, or it would come one or more cycles away from the expected cycle, so every response that ends a command in the sweep exposes it at once. A wrong window counter would show as a timeout raised early or late, or as a late start bit being rejected, within 65 cycles of the strobe. A state machine that keeps stale state would show as a missing or extra completion pulse for the next command.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;

  typedef enum logic [1:0] {
    RSP_NONE    = 2'b00,
    RSP_SHORT   = 2'b01,
    RSP_LONG    = 2'b10,
    RSP_SHORT_B = 2'b11
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_RECV = 2'b10
  } chk_state_e;

  typedef struct packed {
    logic timeout;
    logic crc;
    logic endbit;
    logic index;
    logic done;
  } chk_result_t;

endpackage

// File: rtl/sd_rsp_crc7.sv
module sd_rsp_crc7 #(
  parameter int              CRC_W = 7,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb  = bit_in ^ crc_q[CRC_W-1];
  assign crc = crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr) begin
      crc_q <= '0;
    end else if (en) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
    end
  end

endmodule

// File: rtl/sd_rsp_window.sv
module sd_rsp_window #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  // R3: the counter never runs past the window limit
  a_r3_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sd_rsp_fields.sv
module sd_rsp_fields #(
  parameter int IDX_W     = 6,
  parameter int CRC_W     = 7,
  parameter int IDX_FIRST = 2,
  parameter int CRC_FIRST = 40,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic [CNT_W-1:0] bit_pos,
  input  logic             bit_in,
  output logic [IDX_W-1:0] rx_idx,
  output logic [CRC_W-1:0] rx_crc
);

  localparam logic [CNT_W-1:0] IDX_LO = CNT_W'(IDX_FIRST);
  localparam logic [CNT_W-1:0] IDX_HI = CNT_W'(IDX_FIRST + IDX_W - 1);
  localparam logic [CNT_W-1:0] CRC_LO = CNT_W'(CRC_FIRST);
  localparam logic [CNT_W-1:0] CRC_HI = CNT_W'(CRC_FIRST + CRC_W - 1);

  logic in_idx, in_crc;

  assign in_idx = bit_valid && (bit_pos >= IDX_LO) && (bit_pos <= IDX_HI);
  assign in_crc = bit_valid && (bit_pos >= CRC_LO) && (bit_pos <= CRC_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_idx <= '0;
      rx_crc <= '0;
    end else begin
      if (in_idx) rx_idx <= {rx_idx[IDX_W-2:0], bit_in};
      if (in_crc) rx_crc <= {rx_crc[CRC_W-2:0], bit_in};
    end
  end

endmodule

// File: rtl/sd_rsp_checker.sv
module sd_rsp_checker
  import sd_rsp_pkg::*;
#(
  parameter int WAIT_CYCLES = 64,
  parameter int SHORT_BITS  = 48,
  parameter int LONG_BITS   = 136,
  parameter int IDX_W       = 6,
  parameter int CRC_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_in,
  input  logic             cmd_sent,
  input  logic [1:0]       rsp_type,
  input  logic [IDX_W-1:0] exp_idx,
  input  logic             crc_chk_en,
  input  logic             idx_chk_en,
  output logic             err_timeout,
  output logic             err_crc,
  output logic             err_endbit,
  output logic             err_index,
  output logic             cmd_done
);

  localparam int CNT_W     = $clog2(LONG_BITS + 1);
  localparam int IDX_FIRST = 2;
  localparam int CRC_FIRST = SHORT_BITS - 1 - CRC_W;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] CRC_LO     = CNT_W'(CRC_FIRST);

  chk_state_e       state_q;
  logic [CNT_W-1:0] bcnt_q;
  logic             long_q, ce_q, ie_q;
  logic [IDX_W-1:0] idx_q;
  chk_result_t      res_q;

  logic             accept, start_seen, in_rsp, last_bit, crc_feed, expired;
  logic [CRC_W-1:0] crc_calc, rx_crc;
  logic [IDX_W-1:0] rx_idx;
  logic             e_end, e_crc, e_idx;

  assign accept     = (state_q == ST_IDLE) && cmd_sent;
  assign start_seen = (state_q == ST_WAIT) && !cmd_in;
  assign in_rsp     = (state_q == ST_RECV);
  assign last_bit   = in_rsp && (bcnt_q == (long_q ? LONG_LAST : SHORT_LAST));
  assign crc_feed   = start_seen || (in_rsp && (bcnt_q < CRC_LO));

  assign e_end = !cmd_in;
  assign e_crc = !long_q && ce_q && (rx_crc != crc_calc);
  assign e_idx = !long_q && ie_q && (rx_idx != idx_q);

  sd_rsp_crc7 #(.CRC_W(CRC_W), .POLY(CRC_W'(7'h09))) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .en     (crc_feed),
    .bit_in (cmd_in),
    .crc    (crc_calc)
  );

  sd_rsp_window #(.LIMIT(WAIT_CYCLES)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_WAIT),
    .expired (expired)
  );

  sd_rsp_fields #(
    .IDX_W(IDX_W), .CRC_W(CRC_W), .IDX_FIRST(IDX_FIRST),
    .CRC_FIRST(CRC_FIRST), .CNT_W(CNT_W)
  ) u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (in_rsp),
    .bit_pos   (bcnt_q),
    .bit_in    (cmd_in),
    .rx_idx    (rx_idx),
    .rx_crc    (rx_crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      long_q  <= 1'b0;
      ce_q    <= 1'b0;
      ie_q    <= 1'b0;
      idx_q   <= '0;
      res_q   <= '0;
    end else begin
      res_q <= '0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_sent) begin
            idx_q <= exp_idx;
            ce_q  <= crc_chk_en;
            ie_q  <= idx_chk_en;
            if (rsp_kind_e'(rsp_type) == RSP_NONE) begin
              res_q.done <= 1'b1;
            end else begin
              long_q  <= (rsp_kind_e'(rsp_type) == RSP_LONG);
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (!cmd_in) begin
            bcnt_q  <= CNT_W'(1);
            state_q <= ST_RECV;
          end else if (expired) begin
            res_q.timeout <= 1'b1;
            state_q       <= ST_IDLE;
          end
        end
        ST_RECV: begin
          if (last_bit) begin
            res_q.endbit <= e_end;
            res_q.crc    <= e_crc;
            res_q.index  <= e_idx;
            res_q.done   <= !(e_end || e_crc || e_idx);
            state_q      <= ST_IDLE;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign err_timeout = res_q.timeout;
  assign err_crc     = res_q.crc;
  assign err_endbit  = res_q.endbit;
  assign err_index   = res_q.index;
  assign cmd_done    = res_q.done;

  // R11: completion never coincides with any error
  a_r11_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !(err_timeout || err_crc || err_endbit || err_index));

  // R3: a timeout only follows a cycle spent waiting for the start bit
  a_r3_timeout_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> $past(state_q == ST_WAIT));

  // R9: long responses never report field errors
  a_r9_long_no_field_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_crc || err_index) |-> !$past(long_q));

  // R10: no completion can follow a waiting cycle
  a_r10_wait_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |=> !cmd_done);

  // R2: a no-response command completes in the next cycle
  a_r2_none_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd_sent && rsp_type == 2'b00) |=> cmd_done);

  // R6: a zero end bit is reported in the next cycle
  a_r6_endbit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && !cmd_in) |=> err_endbit);

endmodule

// File: tb/sd_rsp_checker_tb_top.sv
`timescale 1ns/1ps
module sd_rsp_checker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_in;
  logic       cmd_sent;
  logic [1:0] rsp_type;
  logic [5:0] exp_idx;
  logic       crc_chk_en;
  logic       idx_chk_en;
  logic       err_timeout, err_crc, err_endbit, err_index, cmd_done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sd_rsp_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .cmd_sent(cmd_sent),
    .rsp_type(rsp_type), .exp_idx(exp_idx), .crc_chk_en(crc_chk_en),
    .idx_chk_en(idx_chk_en), .err_timeout(err_timeout), .err_crc(err_crc),
    .err_endbit(err_endbit), .err_index(err_index), .cmd_done(cmd_done)
  );

  // x^7+x^3+1 by long division of the message shifted up by 7
  function automatic logic [6:0] crc7_ref(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) begin
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    end
    return r[6:0];
  endfunction

  // expected vector order: {timeout, crc, endbit, index, done}
  task automatic check(input logic [4:0] expv, input string tag);
    logic [4:0] got;
    got = {err_timeout, err_crc, err_endbit, err_index, cmd_done};
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got=%b expected=%b", tag, got, expv);
    end
  endtask

  task automatic drive_bit(input logic b);
    cmd_in = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_rsp(input logic [1:0] kind, input logic [5:0] idx,
                         input logic [5:0] sent, input logic [31:0] arg,
                         input logic crc_bad, input logic end_val,
                         input logic ce, input logic ie, input int delay,
                         input int inject, input logic [4:0] expv,
                         input string tag);
    logic [135:0] v;
    logic [6:0]   c;
    int           n;
    cmd_sent = 1'b1; rsp_type = kind; exp_idx = sent;
    crc_chk_en = ce; idx_chk_en = ie; cmd_in = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_sent = 1'b0;
    if (kind == 2'b00) begin
      check(expv, tag);
      drive_bit(1'b1);
      check(5'b0, {tag, " single-cycle pulse"});
      return;
    end
    if (delay > 64) begin
      repeat (63) drive_bit(1'b1);
      check(5'b0, "R4 no timeout before cycle T+65");
      drive_bit(1'b1);
      check(expv, tag);
      drive_bit(1'b1);
      check(5'b0, "R3 timeout is a single pulse");
      return;
    end
    for (int k = 1; k < delay; k++) begin
      if (k == inject) begin cmd_sent = 1'b1; rsp_type = 2'b00; end
      drive_bit(1'b1);
      if (k == inject) begin
        cmd_sent = 1'b0;
        check(5'b0, "R10 strobe while waiting ignored");
      end
    end
    if (kind == 2'b10) begin
      v = {2'b00, 6'h3F, arg, arg, arg, arg[30:0], end_val};
      n = 136;
    end else begin
      c = crc7_ref({2'b00, idx, arg}) ^ {6'b0, crc_bad};
      v = {88'b0, 2'b00, idx, arg, c, end_val};
      n = 48;
    end
    for (int i = n - 1; i >= 0; i--) drive_bit(v[i]);
    check(expv, tag);
    drive_bit(1'b1);
    check(5'b0, {tag, " outputs return low"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish (all R)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] e;
    rst_n = 1'b0; cmd_in = 1'b1; cmd_sent = 1'b0; rsp_type = 2'b00;
    exp_idx = '0; crc_chk_en = 1'b0; idx_chk_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(5'b0, "R1 outputs low in reset");
    rst_n = 1'b1;
    repeat (5) drive_bit(1'b1);
    check(5'b0, "R1 outputs low after reset");

    // R2: no-response commands
    run_rsp(2'b00, 6'd0, 6'd0, 32'd0, 0, 1, 1, 1, 0, 0, 5'b00001, "R2 no-response done");
    run_rsp(2'b00, 6'd0, 6'd9, 32'd0, 0, 1, 0, 0, 0, 0, 5'b00001, "R2 no-response done, checks off");

    // R5/R7/R8: every index, good CRC, both checks on
    for (int i = 0; i < 64; i++) begin
      run_rsp((i % 2 == 0) ? 2'b01 : 2'b11, 6'(i), 6'(i),
              (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0F0F, 0, 1, 1, 1,
              (i % 5) + 1, 0, 5'b00001, "R5 short response good");
    end

    // R4: start bit at every window position
    for (int d = 1; d <= 64; d++) begin
      run_rsp(2'b01, 6'(d), 6'(d), 32'hDEAD_0000 | 32'(d), 0, 1, 1, 1,
              d, 0, 5'b00001, "R4 start bit within window");
    end

    // R3: no response at all
    run_rsp(2'b01, 6'd3, 6'd3, 32'd0, 0, 1, 1, 1, 65, 0, 5'b10000, "R3 timeout");
    run_rsp(2'b10, 6'd3, 6'd3, 32'd0, 0, 1, 1, 1, 65, 0, 5'b10000, "R3 timeout long");

    // R6/R7/R8/R11: all error combinations with both enables
    for (int m = 0; m < 32; m++) begin
      logic cb, ib, eb, ce, ie;
      cb = m[0]; ib = m[1]; eb = m[2]; ce = m[3]; ie = m[4];
      e = {1'b0, cb & ce, eb, ib & ie, 1'b0};
      e[0] = (e[3:1] == 3'b000);
      run_rsp(2'b01, 6'h2A, ib ? 6'h2A ^ 6'h15 : 6'h2A, 32'h1234_5678 + 32'(m),
              cb, !eb, ce, ie, 3, 0, e, "R7 R8 R6 error combination");
    end

    // R9: long responses ignore index and CRC, check end bit
    run_rsp(2'b10, 6'h3F, 6'h01, 32'hCAFE_F00D, 0, 1, 1, 1, 4, 0, 5'b00001, "R9 long good");
    run_rsp(2'b10, 6'h3F, 6'h01, 32'h0000_0001, 0, 0, 1, 1, 7, 0, 5'b00100, "R9 R6 long bad end bit");

    // R10: strobe during the wait is ignored
    run_rsp(2'b01, 6'd17, 6'd17, 32'h5555_AAAA, 0, 1, 1, 1, 10, 4, 5'b00001, "R10 response after ignored strobe");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule